// File: doc/BRIEF.md
# Stalled-Host Four-Line SPI Byte Exchanger

This block swaps one byte with a serial peripheral that has four data lines in each direction, while the host waits in a lengthened bus cycle. The host offers a byte on a valid/ready input. Once it is accepted, the block raises a stall line for a fixed window of 64 clock cycles. A phase counter runs through that window, and fixed counter values decide each action: the outgoing byte leaves as two nibbles, the serial clock makes one excursion away from its idle level and one return, and two incoming nibbles are sampled. When the window closes, the stall drops and the received byte is shown together with a one-cycle done pulse. The write of the outgoing byte and the read of the incoming byte belong to the same host access.

Stall cycles are numbered 0 to 63. Cycle 0 is the first clock period after the accepting edge. An action "at cycle k" takes effect on the clock edge that ends cycle k. Two parameters set the build. `HI_FIRST` (default 1) chooses whether the upper nibble travels first. `CLK_IDLE` (default 0) sets the resting level of the serial clock.

Back-pressure applies only at the input: `in_ready` is low for the whole window, and a valid offer made then is dropped, not queued. The output has no ready. `done` is a one-cycle strobe, and `rx_data` keeps its value until the next exchange completes.

Top module: `nib_spi_xchg`

## Requirements
- R1: After reset: `stall`, `busy` and `done` are low, `in_ready` is high, `spi_sclk` equals `CLK_IDLE`, and `spi_dout` and `rx_data` are zero.
- R2: `in_valid` with `in_ready` high is accepted on a clock edge. From the next cycle, `stall` and `busy` are high for exactly 64 cycles and `in_ready` is low. In the first cycle after that, `in_ready` is high again.
- R3: Stall cycle 0 only aligns the exchange: during it `spi_dout` keeps its previous value and `spi_sclk` stays at its idle level.
- R4: During stall cycles 1 to 32, `spi_dout` carries the first outgoing nibble: `in_data[7:4]` when `HI_FIRST`=1, `in_data[3:0]` when `HI_FIRST`=0. From stall cycle 33 until the next accepted byte, it carries the other nibble.
- R5: `spi_sclk` sits at the level opposite `CLK_IDLE` during stall cycles 17 to 48 and at `CLK_IDLE` at all other times, giving exactly two transitions per exchange.
- R6: `spi_din` is sampled on the edge that ends stall cycle 32 (first nibble) and on the edge that ends cycle 63 (second nibble). `rx_data` becomes {first, second} when `HI_FIRST`=1 and {second, first} when `HI_FIRST`=0. It changes on no other edge.
- R7: `done` is high for exactly one cycle, the first cycle after `stall` falls. The new `rx_data` is valid in that cycle.
- R8: `in_valid` raised while `busy` is high has no effect: the current schedule, `spi_dout` and `rx_data` are unchanged, and no second window follows.
- R9: A byte offered in the cycle where `done` is high is accepted at once and starts a new window without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Block can take a byte (idle) |
| in_data | input | 8 | Outgoing byte |
| stall | output | 1 | Holds the host bus cycle |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle strobe: `rx_data` updated |
| rx_data | output | 8 | Last received byte |
| spi_sclk | output | 1 | Serial clock |
| spi_dout | output | 4 | Data lines toward the peripheral |
| spi_din | input | 4 | Data lines from the peripheral |

## Verification
The bench puts the correct value on `spi_din` only in the cycle just before each sampling edge and drives the complement everywhere else. A block that samples one cycle early or late therefore returns an inverted nibble. It checks the serial clock on both sides of each transition, and the output nibbles in cycles 0, 1, 32 and 33, so a shifted or merged alignment phase shows up as a wrong line value. It raises a second offer in the middle of a window: a block that restarts or reloads would change `spi_dout` or keep `stall` high past cycle 63. A second build with the opposite nibble order and clock polarity runs the same stimulus, so a block that swaps nibbles the wrong way would fail there.

// File: rtl/nsx_pkg.sv
`timescale 1ns/1ps
package nsx_pkg;
  // Schedule events decoded from the phase counter, active for one cycle.
  typedef struct packed {
    logic drv0;   // put first outgoing nibble on the lines
    logic edge0;  // serial clock leaves idle level
    logic mid;    // second outgoing nibble out, first incoming nibble in
    logic edge1;  // serial clock returns to idle
    logic last;   // second incoming nibble in, window closes
  } nsx_evt_t;
endpackage

// File: rtl/nsx_phase_ctr.sv
`timescale 1ns/1ps
module nsx_phase_ctr
  import nsx_pkg::*;
#(
  parameter int GAP = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_req,
  output logic     active,
  output nsx_evt_t evt
);
  localparam int TOTAL = 4 * GAP;
  localparam int PW    = $clog2(TOTAL);
  localparam logic [PW-1:0] P_DRV0  = '0;
  localparam logic [PW-1:0] P_EDGE0 = PW'(GAP);
  localparam logic [PW-1:0] P_MID   = PW'(2 * GAP);
  localparam logic [PW-1:0] P_EDGE1 = PW'(3 * GAP);
  localparam logic [PW-1:0] P_LAST  = PW'(TOTAL - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (active) begin
      if (phase == P_LAST) begin
        active <= 1'b0;
        phase  <= '0;
      end else begin
        phase <= phase + PW'(1);
      end
    end else if (start_req) begin
      active <= 1'b1;
      phase  <= '0;
    end
  end

  always_comb begin
    evt.drv0  = active && (phase == P_DRV0);
    evt.edge0 = active && (phase == P_EDGE0);
    evt.mid   = active && (phase == P_MID);
    evt.edge1 = active && (phase == P_EDGE1);
    evt.last  = active && (phase == P_LAST);
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    active && (phase != P_LAST) |=> active && (phase == $past(phase) + PW'(1))); // R8
  AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    active && (phase == P_LAST) |=> !active); // R2
  AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt)); // R5
endmodule

// File: rtl/nsx_datapath.sv
`timescale 1ns/1ps
module nsx_datapath
  import nsx_pkg::*;
#(
  parameter int NIB      = 4,
  parameter bit HI_FIRST = 1'b1,
  parameter bit CLK_IDLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [2*NIB-1:0] tx_in,
  input  nsx_evt_t         evt,
  input  logic [NIB-1:0]   spi_din,
  output logic [NIB-1:0]   spi_dout,
  output logic             spi_sclk,
  output logic [2*NIB-1:0] rx_data,
  output logic             done
);
  localparam int BW = 2 * NIB;

  logic [BW-1:0]  tx_hold;
  logic [NIB-1:0] tx_first, tx_second, rx_first;

  generate
    if (HI_FIRST) begin : g_hi
      assign tx_first  = tx_hold[BW-1:NIB];
      assign tx_second = tx_hold[NIB-1:0];
    end else begin : g_lo
      assign tx_first  = tx_hold[NIB-1:0];
      assign tx_second = tx_hold[BW-1:NIB];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hold <= '0;
    end else if (load) begin
      tx_hold <= tx_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spi_dout <= '0;
      rx_first <= '0;
    end else if (evt.drv0) begin
      spi_dout <= tx_first;
    end else if (evt.mid) begin
      spi_dout <= tx_second;
      rx_first <= spi_din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spi_sclk <= CLK_IDLE;
    end else if (evt.edge0 || evt.edge1) begin
      spi_sclk <= ~spi_sclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= evt.last;
      if (evt.last) begin
        if (HI_FIRST) rx_data <= {rx_first, spi_din};
        else          rx_data <= {spi_din, rx_first};
      end
    end
  end

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.drv0 || evt.mid) |=> $stable(spi_dout)); // R4
  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.edge0 || evt.edge1) |=> $stable(spi_sclk)); // R5
  AST_SCLK_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    evt.drv0 |-> spi_sclk == CLK_IDLE); // R5
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.last |=> $stable(rx_data)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

// File: rtl/nib_spi_xchg.sv
`timescale 1ns/1ps
module nib_spi_xchg
  import nsx_pkg::*;
#(
  parameter int NIB      = 4,
  parameter int GAP      = 16,
  parameter bit HI_FIRST = 1'b1,
  parameter bit CLK_IDLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2*NIB-1:0] in_data,
  output logic             stall,
  output logic             busy,
  output logic             done,
  output logic [2*NIB-1:0] rx_data,
  output logic             spi_sclk,
  output logic [NIB-1:0]   spi_dout,
  input  logic [NIB-1:0]   spi_din
);
  localparam int TOTAL = 4 * GAP;
  localparam int LW    = $clog2(TOTAL) + 1;

  logic     active;
  logic     accept;
  nsx_evt_t evt;

  assign accept   = in_valid && !active;
  assign in_ready = !active;
  assign busy     = active;
  assign stall    = active;

  nsx_phase_ctr #(.GAP(GAP)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (in_valid),
    .active    (active),
    .evt       (evt)
  );

  nsx_datapath #(.NIB(NIB), .HI_FIRST(HI_FIRST), .CLK_IDLE(CLK_IDLE)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .tx_in    (in_data),
    .evt      (evt),
    .spi_din  (spi_din),
    .spi_dout (spi_dout),
    .spi_sclk (spi_sclk),
    .rx_data  (rx_data),
    .done     (done)
  );

  // Window length monitor
  logic [LW-1:0] chk_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !stall) chk_len <= '0;
    else                  chk_len <= chk_len + LW'(1);
  end

  AST_STALL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> chk_len == LW'(TOTAL)); // R2
  AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall && in_ready); // R9
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall && in_valid |=> stall || done); // R8
endmodule

// File: tb/test_nib_spi_xchg.sv
`timescale 1ns/1ps
module test_nib_spi_xchg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] spi_din = '0;

  logic       in_ready, stall, busy, done, spi_sclk;
  logic [7:0] rx_data;
  logic [3:0] spi_dout;
  logic       a_in_ready, a_stall, a_busy, a_done, a_sclk;
  logic [7:0] a_rx;
  logic [3:0] a_dout;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] exp_a_q[$];
  logic [3:0] prev_d = 4'h0;
  logic [3:0] prev_a = 4'h0;

  always #10 clk = ~clk;

  nib_spi_xchg i_nib_spi_xchg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .stall(stall), .busy(busy), .done(done),
    .rx_data(rx_data), .spi_sclk(spi_sclk), .spi_dout(spi_dout), .spi_din(spi_din)
  );

  nib_spi_xchg #(.HI_FIRST(1'b0), .CLK_IDLE(1'b1)) i_nib_spi_xchg_alt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_in_ready),
    .in_data(in_data), .stall(a_stall), .busy(a_busy), .done(a_done),
    .rx_data(a_rx), .spi_sclk(a_sclk), .spi_dout(a_dout), .spi_din(spi_din)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: pops expected bytes when done strobes
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R7 unexpected done", 1, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R6 rx_data", rx_data, e);
        chk("R7 stall low with done", stall, 0);
      end
    end
    if (rst_n && a_done) begin
      if (exp_a_q.size() == 0) chk("R7 unexpected alt done", 1, 0);
      else begin
        logic [7:0] e;
        e = exp_a_q.pop_front();
        chk("R6 alt rx_data", a_rx, e);
      end
    end
  end

  // Driver: one exchange; chained = valid already raised in this cycle
  task automatic xfer(input logic [7:0] tx, input logic [3:0] n1, input logic [3:0] n2,
                      input bit intrude, input bit chained, input bit chain_next);
    logic [3:0] f, s, fa, sa;
    f = tx[7:4]; s = tx[3:0]; fa = tx[3:0]; sa = tx[7:4];
    if (!chained) @(negedge clk);
    in_valid = 1'b1;
    in_data  = tx;
    chk("R2 ready before accept", in_ready, 1);
    exp_q.push_back({n1, n2});
    exp_a_q.push_back({n2, n1});
    @(posedge clk);
    for (int k = 0; k <= 64; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (intrude && k == 10) begin in_valid = 1'b1; in_data = ~tx; end
      spi_din = (k == 32) ? n1 : (k == 63) ? n2 : (k < 32) ? ~n1 : ~n2;
      case (k)
        0: begin
          chk("R3 dout held", spi_dout, prev_d);
          chk("R3 alt dout held", a_dout, prev_a);
          chk("R3 sclk idle", spi_sclk, 0);
          chk("R2 stall up", stall, 1);
          chk("R2 busy up", busy, 1);
        end
        1:  begin chk("R4 first nib", spi_dout, f); chk("R4 alt first nib", a_dout, fa); end
        10: chk("R2 ready low", in_ready, 0);
        16: begin chk("R5 sclk idle c16", spi_sclk, 0); chk("R5 alt idle c16", a_sclk, 1); end
        17: begin chk("R5 sclk active c17", spi_sclk, 1); chk("R5 alt active c17", a_sclk, 0); end
        32: chk("R4 first nib c32", spi_dout, f);
        33: begin chk("R4 second nib", spi_dout, s); chk("R4 alt second nib", a_dout, sa); end
        48: chk("R5 sclk active c48", spi_sclk, 1);
        49: begin chk("R5 sclk idle c49", spi_sclk, 0); chk("R5 alt idle c49", a_sclk, 1); end
        63: chk("R2 stall c63", stall, 1);
        64: begin
          chk("R2 stall released", stall, 0);
          chk("R2 ready back", in_ready, 1);
          chk("R7 done strobe", done, 1);
          chk("R8 dout kept", spi_dout, s);
        end
        default: ;
      endcase
    end
    prev_d = s;
    prev_a = sa;
    if (!chain_next) begin
      @(negedge clk);
      chk("R7 done one cycle", done, 0);
      if (intrude) chk("R8 no second window", stall, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 stall", stall, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ready", in_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 sclk", spi_sclk, 0);
    chk("R1 alt sclk", a_sclk, 1);
    chk("R1 dout", spi_dout, 0);
    chk("R1 rx", rx_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", stall, 0);

    xfer(8'hA5, 4'h3, 4'hC, 1'b0, 1'b0, 1'b0);
    xfer(8'h0F, 4'hF, 4'h0, 1'b0, 1'b0, 1'b0);
    xfer(8'h96, 4'h7, 4'h1, 1'b1, 1'b0, 1'b0);   // R8 offer mid-window
    xfer(8'h3C, 4'hE, 4'h5, 1'b0, 1'b0, 1'b1);   // R9 chained pair
    xfer(8'hC3, 4'h2, 4'h9, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 all results seen", exp_q.size(), 0);
    chk("R7 all alt results seen", exp_a_q.size(), 0);
    finish_run();
  end
endmodule